// File: doc/BRIEF.md
# Transaction ID Compression Allocator

This block shrinks the identifier that travels with each transaction. A request is tagged with a wide key made of the initiator number and the initiator's own tag. The block swaps that key for a short compact ID and drives it back in the same cycle. Two requests with the same key get the same compact ID while the key has work in flight, so their responses stay in order. Keys that differ get different compact IDs, so their completions may return in any order.

At reset, every compact ID sits in a free list, a FIFO loaded with 0, 1, 2 and so on upward. A key with no live mapping takes the ID at the head of that FIFO. Each compact ID has an outstanding counter. A request raises it, a completion lowers it, and when it reaches zero the ID is released and appended to the tail of the FIFO. A combinational reverse port turns any compact ID back into its initiator number and tag, so a response can be routed home.

Top module: `txn_id_compressor`

## Requirements
- R1: After reset no compact ID is active (`lk_active` is 0 for every ID), and the first new key is given compact ID 0.
- R2: A request whose key has no active mapping is accepted when the free FIFO is not empty. It gets the ID at the head of the FIFO. With no releases in between, new keys are therefore served in order 0, 1, 2, ...
- R3: A request whose key matches an active mapping gets that same compact ID, and the ID's outstanding count rises by one.
- R4: Keys that are active at the same time always hold different compact IDs.
- R5: A completion on an active ID lowers its count by one. When the count reaches zero the ID turns inactive and goes to the tail of the free FIFO, so it is handed out again after the IDs already queued.
- R6: A request for a new key while the free FIFO is empty is stalled: `req_ready` is 0 and no state changes.
- R7: A request for an active key whose count is at its maximum (2^CNT_W − 1) is stalled, even when a completion for that ID arrives in the same cycle.
- R8: For any `lk_cid` whose mapping is active, `lk_src` and `lk_tag` show the initiator number and tag bound to it, in the same cycle.
- R9: A completion that names an inactive ID has no effect. The ID stays inactive and the order of the free FIFO does not change.
- R10: When a request for an active key and a completion on the same ID fall in the same cycle, the count is unchanged and the ID stays active.
- R11: When a release and an accepted new-key request fall in the same cycle, both take effect. A released ID is never entered into the free FIFO twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_src | input | SRC_W | Initiator number of the request |
| req_tag | input | TAG_W | Initiator tag of the request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_cid | output | CID_W | Compact ID given to the request (valid when `req_ready`) |
| cpl_valid | input | 1 | Completion present |
| cpl_cid | input | CID_W | Compact ID being completed |
| lk_cid | input | CID_W | Compact ID to translate back |
| lk_src | output | SRC_W | Initiator number bound to `lk_cid` |
| lk_tag | output | TAG_W | Tag bound to `lk_cid` |
| lk_active | output | 1 | `lk_cid` currently has work outstanding |

## Verification
The bench works on a four-ID, two-bit-counter build and goes after the edges of the ID life cycle. These are: draining the pool, where a design that ignores emptiness would hand out a stale head ID twice; saturating a counter, where a missing stall would wrap the count and free an ID that still has work in flight; and a completion on a free ID, which a careless design would turn into a second FIFO entry. It also drives a request and a completion on the same ID in the same cycle, and a release together with a new allocation. A design that let either update override the other would lose a count or an ID. A long stretch of mixed traffic with more keys than IDs follows, checked cycle by cycle against an arithmetic model of the pool, the counters and the reverse table.

// File: rtl/cidc_pkg.sv
// Package cidc_pkg: default sizes and shared helpers for the ID compression allocator.
// Assumes: nothing beyond IEEE 1800-2017.
package cidc_pkg;
    localparam int unsigned DEF_SRC_W = 4;
    localparam int unsigned DEF_TAG_W = 3;
    localparam int unsigned DEF_IDS   = 4;
    localparam int unsigned DEF_CNT_W = 2;

    // Index width for n entries, never below one bit.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/cidc_free_fifo.sv
// Module cidc_free_fifo: circular list of free compact IDs, loaded with 0..DEPTH-1 at reset.
// Assumes: the caller never pushes an ID that is already queued, and never pops when empty.
module cidc_free_fifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_id,
    input  logic         pop,
    output logic [W-1:0] head_id,
    output logic         empty
);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rd_ptr, wr_ptr;
    logic [W:0]   fill;

    // Advance a pointer with wrap at DEPTH-1.
    function automatic logic [W-1:0] step_ptr(input logic [W-1:0] p);
        return (p == W'(DEPTH - 1)) ? '0 : p + W'(1);
    endfunction

    // Preload every ID on reset, otherwise apply push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= W'(i);
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= (W+1)'(DEPTH);
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_id;
                wr_ptr      <= step_ptr(wr_ptr);
            end
            if (pop) rd_ptr <= step_ptr(rd_ptr);
            fill <= fill + (W+1)'(push) - (W+1)'(pop);
        end
    end

    // Head and empty flag for the allocator.
    assign head_id = mem[rd_ptr];
    assign empty   = (fill == '0);

    // R11: a release never lands on a full list (no duplicate ID).
    a_r11_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (fill != (W+1)'(DEPTH)));
    // R6: no ID is taken from an empty list.
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/cidc_slot.sv
// Module cidc_slot: state of one compact ID: active flag, bound key and outstanding count.
// Assumes: claim only when inactive, bump only when active and below the count limit.
module cidc_slot #(
    parameter int unsigned KEY_W = 7,
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim,
    input  logic [KEY_W-1:0] claim_key,
    input  logic             bump,
    input  logic             drop,
    output logic             active,
    output logic [KEY_W-1:0] key,
    output logic [CNT_W-1:0] cnt,
    output logic             release_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic drop_eff;

    // A completion only counts on an active ID; the last one releases it.
    assign drop_eff  = drop && active;
    assign release_o = drop_eff && !bump && (cnt == CNT_W'(1));

    // Bind on claim, track the count, and clear on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            key    <= '0;
            cnt    <= '0;
        end else if (claim) begin
            active <= 1'b1;
            key    <= claim_key;
            cnt    <= CNT_W'(1);
        end else if (active) begin
            cnt <= cnt + CNT_W'(bump) - CNT_W'(drop_eff);
            if (release_o) active <= 1'b0;
        end
    end

    // R2: a fresh claim only takes a free ID.
    a_r2_claim_free: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> !active);
    // R7: the count is never pushed past its limit.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        bump |-> (active && cnt != CNT_MAX));
    // R5: a release leaves the slot inactive with a zero count.
    a_r5_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> (!active && cnt == '0));
endmodule

// File: rtl/txn_id_compressor.sv
// Module txn_id_compressor: maps {initiator, tag} keys to recycled compact IDs.
// Searches active slots for the key. On a hit it reuses the ID, on a miss it pops the
// free list. Completions lower the counts and the last one returns the ID to the list.
// Assumes: CID_W is narrower than SRC_W+TAG_W; the reverse lookup is combinational.
module txn_id_compressor #(
    parameter int unsigned SRC_W   = cidc_pkg::DEF_SRC_W,
    parameter int unsigned TAG_W   = cidc_pkg::DEF_TAG_W,
    parameter int unsigned NUM_IDS = cidc_pkg::DEF_IDS,
    parameter int unsigned CNT_W   = cidc_pkg::DEF_CNT_W,
    localparam int unsigned CID_W  = cidc_pkg::idx_w(NUM_IDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SRC_W-1:0] req_src,
    input  logic [TAG_W-1:0] req_tag,
    output logic             req_ready,
    output logic [CID_W-1:0] req_cid,
    input  logic             cpl_valid,
    input  logic [CID_W-1:0] cpl_cid,
    input  logic [CID_W-1:0] lk_cid,
    output logic [SRC_W-1:0] lk_src,
    output logic [TAG_W-1:0] lk_tag,
    output logic             lk_active
);
    localparam int unsigned      KEY_W   = SRC_W + TAG_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [KEY_W-1:0]   req_key;
    logic [NUM_IDS-1:0] s_active, s_claim, s_bump, s_drop, s_rel, hit_vec;
    logic [KEY_W-1:0]   s_key [NUM_IDS];
    logic [CNT_W-1:0]   s_cnt [NUM_IDS];
    logic               hit;
    logic [CID_W-1:0]   hit_idx;
    logic [CID_W-1:0]   free_head;
    logic               free_empty;
    logic               accept;
    logic               fifo_pop, fifo_push;

    assign req_key = {req_src, req_tag};

    // Search the active slots for the incoming key.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        hit_vec = '0;
        for (int i = 0; i < int'(NUM_IDS); i++) begin
            if (s_active[i] && s_key[i] == req_key) begin
                hit_vec[i] = 1'b1;
                hit        = 1'b1;
                hit_idx    = CID_W'(i);
            end
        end
    end

    // Accept on a hit below the limit, or on a miss with a free ID.
    always_comb begin
        if (hit) req_ready = (s_cnt[hit_idx] != CNT_MAX);
        else     req_ready = !free_empty;
        req_cid = hit ? hit_idx : free_head;
    end

    assign accept    = req_valid && req_ready;
    assign fifo_pop  = accept && !hit;
    assign fifo_push = |s_rel;

    // Per-ID slots, one per compact ID.
    for (genvar g = 0; g < int'(NUM_IDS); g++) begin : g_slot
        assign s_claim[g] = fifo_pop && (free_head == CID_W'(g));
        assign s_bump[g]  = accept && hit && (hit_idx == CID_W'(g));
        assign s_drop[g]  = cpl_valid && (cpl_cid == CID_W'(g));

        cidc_slot #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .claim     (s_claim[g]),
            .claim_key (req_key),
            .bump      (s_bump[g]),
            .drop      (s_drop[g]),
            .active    (s_active[g]),
            .key       (s_key[g]),
            .cnt       (s_cnt[g]),
            .release_o (s_rel[g])
        );
    end

    // Free list of compact IDs; a release always names the completed ID.
    cidc_free_fifo #(.DEPTH(NUM_IDS), .W(CID_W)) u_free (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (fifo_push),
        .push_id (cpl_cid),
        .pop     (fifo_pop),
        .head_id (free_head),
        .empty   (free_empty)
    );

    // Reverse translation from compact ID to the original key.
    always_comb begin
        if (int'(lk_cid) < int'(NUM_IDS)) begin
            lk_active        = s_active[lk_cid];
            {lk_src, lk_tag} = s_key[lk_cid];
        end else begin
            lk_active        = 1'b0;
            {lk_src, lk_tag} = '0;
        end
    end

    // R4: a key matches at most one active ID.
    a_r4_unique_key: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    // R11: at most one ID is released per cycle.
    a_r11_single_release: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_rel));
    // R3: an accepted hit leaves its ID active in the next cycle.
    a_r3_hit_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> s_active[$past(hit_idx)]);
endmodule

// File: tb/sim_txn_id_compressor.sv
// Bench: four compact IDs, two-bit counters, checked against an arithmetic pool model.
module sim_txn_id_compressor;
    localparam int CLK_P = 20;
    localparam int NIDS  = 4;
    localparam int CMAX  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_src = '0;
    logic [2:0] req_tag = '0;
    logic       req_ready;
    logic [1:0] req_cid;
    logic       cpl_valid = 1'b0;
    logic [1:0] cpl_cid = '0;
    logic [1:0] lk_cid = '0;
    logic [3:0] lk_src;
    logic [2:0] lk_tag;
    logic       lk_active;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    int m_act [NIDS];
    int m_src [NIDS];
    int m_tag [NIDS];
    int m_cnt [NIDS];
    int fq [NIDS];
    int fh, ft, fc;

    always #(CLK_P/2) clk = ~clk;

    txn_id_compressor #(.SRC_W(4), .TAG_W(3), .NUM_IDS(NIDS), .CNT_W(2)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_src(req_src), .req_tag(req_tag),
        .req_ready(req_ready), .req_cid(req_cid),
        .cpl_valid(cpl_valid), .cpl_cid(cpl_cid),
        .lk_cid(lk_cid), .lk_src(lk_src), .lk_tag(lk_tag), .lk_active(lk_active)
    );

    task automatic chk(input bit ok, input string lbl, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", lbl, what, act, exp);
        end
    endtask

    // One cycle: drive, check outputs against the model, clock, update the model.
    task automatic step(input bit rv, input int s, input int t, input bit cv, input int c, input string lbl);
        bit hit, exp_rdy, acc;
        int hi, exp_cid, id;
        bit dec_ok;
        @(negedge clk);
        req_valid = rv; req_src = 4'(s); req_tag = 3'(t);
        cpl_valid = cv; cpl_cid = 2'(c);
        #1;
        hit = 0; hi = 0;
        for (int i = 0; i < NIDS; i++)
            if (m_act[i] != 0 && m_src[i] == s && m_tag[i] == t) begin hit = 1; hi = i; end
        exp_rdy = hit ? (m_cnt[hi] < CMAX) : (fc > 0);
        exp_cid = hit ? hi : fq[fh];
        chk(req_ready == exp_rdy, lbl, "req_ready", int'(req_ready), int'(exp_rdy));
        if (exp_rdy) chk(int'(req_cid) == exp_cid, lbl, "req_cid", int'(req_cid), exp_cid);
        for (int l = 0; l < NIDS; l++) begin
            lk_cid = 2'(l);
            #1;
            chk(int'(lk_active) == m_act[l], "R8", "lk_active", int'(lk_active), m_act[l]);
            if (m_act[l] != 0) begin
                chk(int'(lk_src) == m_src[l], "R8", "lk_src", int'(lk_src), m_src[l]);
                chk(int'(lk_tag) == m_tag[l], "R8", "lk_tag", int'(lk_tag), m_tag[l]);
            end
        end
        @(posedge clk);
        acc = rv && exp_rdy;
        dec_ok = cv && (m_act[c] != 0);
        if (acc && hit) m_cnt[hi]++;
        else if (acc) begin
            id = fq[fh]; fh = (fh + 1) % NIDS; fc--;
            m_act[id] = 1; m_src[id] = s; m_tag[id] = t; m_cnt[id] = 1;
        end
        if (dec_ok) begin
            m_cnt[c]--;
            if (m_cnt[c] == 0) begin
                m_act[c] = 0; fq[ft] = c; ft = (ft + 1) % NIDS; fc++;
            end
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NIDS; i++) begin
            m_act[i] = 0; m_src[i] = 0; m_tag[i] = 0; m_cnt[i] = 0; fq[i] = i;
        end
        fh = 0; ft = 0; fc = NIDS;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        step(0, 0, 0, 0, 0, "R1");              // R1: idle after reset, head is ID 0
        step(1, 1, 2, 0, 0, "R1");              // R1: first key gets ID 0
        step(1, 2, 5, 0, 0, "R2");              // R2: order 1
        step(1, 3, 0, 0, 0, "R4");              // R4: distinct keys, ID 2
        step(1, 4, 7, 0, 0, "R4");              // R4: ID 3
        step(1, 5, 1, 0, 0, "R6");              // R6: pool empty, stall
        step(1, 1, 2, 0, 0, "R3");              // R3: reuse ID 0, count 2
        step(1, 1, 2, 0, 0, "R3");              // R3: count 3
        step(1, 1, 2, 0, 0, "R7");              // R7: count at max, stall
        step(1, 1, 2, 1, 0, "R7");              // R7: still stalled with same-cycle completion
        step(0, 0, 0, 1, 1, "R5");              // R5: release ID 1
        step(1, 5, 3, 0, 0, "R5");              // R5: new key takes ID 1
        step(0, 0, 0, 1, 2, "R5");              // R5: release ID 2
        step(0, 0, 0, 1, 2, "R9");              // R9: completion on free ID ignored
        step(1, 6, 6, 0, 0, "R9");              // R9: head still ID 2
        step(1, 6, 6, 1, 2, "R10");             // R10: hit + completion on ID 2
        step(0, 0, 0, 0, 0, "R10");             // R10: ID 2 still active
        step(1, 7, 4, 1, 3, "R11");             // R11: release ID 3 while pool empty
        step(1, 7, 4, 1, 1, "R11");             // R11: release ID 1 and take ID 3
        step(1, 2, 2, 0, 0, "R11");             // R11: ID 1 handed out once

        for (int k = 0; k < 4000; k++)
            step(($urandom % 4) != 0, $urandom % 3, $urandom % 2,
                 ($urandom % 2) != 0, $urandom % NIDS, "R11");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule